// File: doc/BRIEF.md
# Configurable Logic-Array Output Cell

This block is one output cell of a small programmable logic device. It receives the product terms that the logic array has produced for it. It forms their sum, applies a selectable output polarity, and then routes the result one of three ways: through a clocked register, straight out to the pin, or nowhere, when the cell is used as an input. It also chooses what goes back into the array as feedback: the registered value, the level on its own pin, or the level on a neighbouring pin.

Four configuration bits set the cell's behaviour. Two are shared by every cell of the device and two belong to this cell alone. The position of the cell in the row is fixed when the block is instantiated. End cells and the two centre cells differ slightly in how their feedback is chosen.

For board test, an asynchronous reset models power-up. A preload strobe forces an arbitrary value into the register, so that a state machine can be placed directly into any state, including illegal ones.

Top module: `pld_out_cell`

## Requirements
- R1: The mode is decoded from (g_sel0, g_sel1, l_sel). The codes are: (0,1,0) registered; (0,1,1) combinational I/O in a registered device; (1,0,0) combinational dedicated output; (1,0,1) dedicated input; (1,1,1) combinational I/O in a non-registered device. Every other code is undefined.
- R2: The combinational value equals the OR of the active product terms when l_pol is 1, and the inverse of that OR when l_pol is 0.
- R3: In registered mode, pin_o takes the R2 value of the terms sampled at each rising clock edge. pin_en_o follows oe_i, and fb_o equals pin_o.
- R4: In both combinational I/O modes, only terms [N_TERMS-2:0] enter the OR. Term [N_TERMS-1] drives pin_en_o, and fb_o is pin_i, except as stated in R8.
- R5: In dedicated-output mode, all terms enter the OR and pin_en_o is 1. fb_o is adj_i, except that a centre cell (CELL_KIND 2) gives fb_o = 0.
- R6: In dedicated-input mode, pin_en_o is 0, pin_o is 0, and fb_o is adj_i.
- R7: An undefined code drives pin_en_o = 0, pin_o = 0 and fb_o = 0.
- R8: An end cell (CELL_KIND 1) steers its feedback with the inverse of g_sel0 in place of g_sel1. As a result, in mode (1,1,1) its fb_o is adj_i.
- R9: While rst is high, the stored bit is cleared, and a registered pin_o reads 1 whatever the value of l_pol.
- R10: When pre_ld_i is high at a rising edge, the register loads pre_dat_i as its pin level, overriding the next-state value for that edge. Reset takes priority over preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Active-high asynchronous power-up reset |
| term_i | input | N_TERMS | Product terms from the logic array |
| oe_i | input | 1 | Global output enable for registered mode |
| pin_i | input | 1 | Level on this cell's own pin |
| adj_i | input | 1 | Level on the adjacent pin (for end cells: the clock or enable pin) |
| g_sel0 | input | 1 | Global bit: set when the device uses no registers |
| g_sel1 | input | 1 | Global bit: device style |
| l_sel | input | 1 | Local mode bit |
| l_pol | input | 1 | Local polarity bit, 1 = active high |
| pre_ld_i | input | 1 | Preload strobe |
| pre_dat_i | input | 1 | Preload pin level |
| pin_o | output | 1 | Value driven to the pin |
| pin_en_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback into the logic array |

## Verification
Every combinational result (pin_o outside registered mode, pin_en_o and fb_o) is due in the same cycle that its inputs change. The bench therefore drives on the falling edge and samples one nanosecond later, before any rising edge can occur. A registered pin_o, and a preloaded value, appear exactly one rising edge after they are applied, so those checks drive on a falling edge, wait for the next rising edge, and sample one nanosecond after it. The reset value is checked while rst is still high, because the reset is asynchronous and needs no clock edge.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

   typedef enum logic [2:0] {
      CM_REG   = 3'd0,
      CM_CIO_R = 3'd1,
      CM_DOUT  = 3'd2,
      CM_DIN   = 3'd3,
      CM_CIO_N = 3'd4,
      CM_BAD   = 3'd5
   } cell_mode_e;

   localparam int KIND_INNER = 0;
   localparam int KIND_EDGE  = 1;
   localparam int KIND_MID   = 2;

   function automatic cell_mode_e decode_mode(input logic g0, input logic g1, input logic l);
      cell_mode_e m;
      case ({g0, g1, l})
         3'b010:  m = CM_REG;
         3'b011:  m = CM_CIO_R;
         3'b100:  m = CM_DOUT;
         3'b101:  m = CM_DIN;
         3'b111:  m = CM_CIO_N;
         default: m = CM_BAD;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/pld_cell_decode.sv
module pld_cell_decode
   import pld_cell_pkg::*;
(
   input  logic       g_sel0,
   input  logic       g_sel1,
   input  logic       l_sel,
   output cell_mode_e mode_o,
   output logic       seven_o
);
   always_comb begin
      mode_o  = decode_mode(g_sel0, g_sel1, l_sel);
      seven_o = (mode_o == CM_CIO_R) || (mode_o == CM_CIO_N);
   end
endmodule

// File: rtl/pld_cell_sum.sv
module pld_cell_sum #(
   parameter int N_TERMS = 8
) (
   input  logic [N_TERMS-1:0] term_i,
   input  logic               seven_i,
   input  logic               pol_i,
   output logic               val_o
);
   localparam int LOW_W = N_TERMS - 1;

   logic low_or;
   logic top_term;
   logic sum;

   assign low_or   = |term_i[LOW_W-1:0];
   assign top_term = term_i[N_TERMS-1] & ~seven_i;
   assign sum      = low_or | top_term;
   assign val_o    = sum ^ ~pol_i;
endmodule

// File: rtl/pld_cell_reg.sv
module pld_cell_reg (
   input  logic clk,
   input  logic rst,
   input  logic nxt_i,
   input  logic pre_ld_i,
   input  logic pre_dat_i,
   output logic pin_lvl_o
);
   logic q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         q <= 1'b0;
      else if (pre_ld_i)
         q <= ~pre_dat_i;
      else
         q <= ~nxt_i;
   end

   assign pin_lvl_o = ~q;
endmodule

// File: rtl/pld_cell_fbmux.sv
module pld_cell_fbmux
   import pld_cell_pkg::*;
#(
   parameter int CELL_KIND = KIND_INNER
) (
   input  cell_mode_e mode_i,
   input  logic       g_sel0,
   input  logic       g_sel1,
   input  logic       l_sel,
   input  logic       reg_i,
   input  logic       pin_i,
   input  logic       adj_i,
   output logic       fb_o
);
   localparam bit IS_EDGE = (CELL_KIND == KIND_EDGE);
   localparam bit IS_MID  = (CELL_KIND == KIND_MID);

   logic steer;
   logic raw;

   assign steer = IS_EDGE ? ~g_sel0 : g_sel1;

   always_comb begin
      case ({steer, l_sel})
         2'b10:   raw = reg_i;
         2'b11:   raw = pin_i;
         default: raw = adj_i;
      endcase
      if (mode_i == CM_BAD)
         fb_o = 1'b0;
      else if (IS_MID && mode_i == CM_DOUT)
         fb_o = 1'b0;
      else
         fb_o = raw;
   end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
   import pld_cell_pkg::*;
#(
   parameter int N_TERMS   = 8,
   parameter int CELL_KIND = KIND_INNER
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_TERMS-1:0] term_i,
   input  logic               oe_i,
   input  logic               pin_i,
   input  logic               adj_i,
   input  logic               g_sel0,
   input  logic               g_sel1,
   input  logic               l_sel,
   input  logic               l_pol,
   input  logic               pre_ld_i,
   input  logic               pre_dat_i,
   output logic               pin_o,
   output logic               pin_en_o,
   output logic               fb_o
);
   localparam int EN_IDX = N_TERMS - 1;

   generate
      if (N_TERMS < 2) begin : g_bad_terms
         $error("pld_out_cell: N_TERMS must be at least 2");
      end
      if (CELL_KIND < KIND_INNER || CELL_KIND > KIND_MID) begin : g_bad_kind
         $error("pld_out_cell: CELL_KIND out of range");
      end
   endgenerate

   cell_mode_e mode;
   logic       seven;
   logic       comb_val;
   logic       reg_lvl;

   pld_cell_decode u_dec (
      .g_sel0 (g_sel0),
      .g_sel1 (g_sel1),
      .l_sel  (l_sel),
      .mode_o (mode),
      .seven_o(seven)
   );

   pld_cell_sum #(.N_TERMS(N_TERMS)) u_sum (
      .term_i (term_i),
      .seven_i(seven),
      .pol_i  (l_pol),
      .val_o  (comb_val)
   );

   pld_cell_reg u_reg (
      .clk      (clk),
      .rst      (rst),
      .nxt_i    (comb_val),
      .pre_ld_i (pre_ld_i),
      .pre_dat_i(pre_dat_i),
      .pin_lvl_o(reg_lvl)
   );

   pld_cell_fbmux #(.CELL_KIND(CELL_KIND)) u_fb (
      .mode_i(mode),
      .g_sel0(g_sel0),
      .g_sel1(g_sel1),
      .l_sel (l_sel),
      .reg_i (reg_lvl),
      .pin_i (pin_i),
      .adj_i (adj_i),
      .fb_o  (fb_o)
   );

   always_comb begin
      case (mode)
         CM_REG: begin
            pin_o    = reg_lvl;
            pin_en_o = oe_i;
         end
         CM_CIO_R, CM_CIO_N: begin
            pin_o    = comb_val;
            pin_en_o = term_i[EN_IDX];
         end
         CM_DOUT: begin
            pin_o    = comb_val;
            pin_en_o = 1'b1;
         end
         default: begin
            pin_o    = 1'b0;
            pin_en_o = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
   parameter int N_TERMS = 8
) (
   input logic               clk,
   input logic               rst,
   input logic [N_TERMS-1:0] term_i,
   input logic               oe_i,
   input logic               adj_i,
   input logic               g_sel0,
   input logic               g_sel1,
   input logic               l_sel,
   input logic               l_pol,
   input logic               pre_ld_i,
   input logic               pre_dat_i,
   input logic               pin_o,
   input logic               pin_en_o,
   input logic               fb_o
);
   logic [2:0] code;
   logic is_reg, is_cio, is_din, is_bad, full_val;

   assign code     = {g_sel0, g_sel1, l_sel};
   assign is_reg   = (code == 3'b010);
   assign is_cio   = (code == 3'b011) || (code == 3'b111);
   assign is_din   = (code == 3'b101);
   assign is_bad   = (code == 3'b000) || (code == 3'b001) || (code == 3'b110);
   assign full_val = l_pol ? (|term_i) : ~(|term_i);

   assert_reg_next_R3: assert property (@(posedge clk) disable iff (rst)
      (is_reg && !pre_ld_i) |=> (!is_reg || pin_o == $past(full_val)));

   assert_reg_en_fb_R3: assert property (@(posedge clk) disable iff (rst)
      is_reg |-> (pin_en_o == oe_i && fb_o == pin_o));

   assert_cio_en_R4: assert property (@(posedge clk) disable iff (rst)
      is_cio |-> (pin_en_o == term_i[N_TERMS-1]));

   assert_din_R6: assert property (@(posedge clk) disable iff (rst)
      is_din |-> (!pin_en_o && fb_o == adj_i));

   assert_undef_R7: assert property (@(posedge clk) disable iff (rst)
      is_bad |-> (!pin_en_o && !pin_o && !fb_o));

   assert_preload_R10: assert property (@(posedge clk) disable iff (rst)
      (pre_ld_i && is_reg) |=> (!is_reg || pin_o == $past(pre_dat_i)));

   assert_reset_R9: assert property (@(posedge clk)
      (rst && is_reg) |-> pin_o);
endmodule

bind pld_out_cell pld_out_cell_chk #(.N_TERMS(N_TERMS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .term_i   (term_i),
   .oe_i     (oe_i),
   .adj_i    (adj_i),
   .g_sel0   (g_sel0),
   .g_sel1   (g_sel1),
   .l_sel    (l_sel),
   .l_pol    (l_pol),
   .pre_ld_i (pre_ld_i),
   .pre_dat_i(pre_dat_i),
   .pin_o    (pin_o),
   .pin_en_o (pin_en_o),
   .fb_o     (fb_o)
);

// File: tb/test_pld_out_cell.sv
`timescale 1ns/1ps
module test_pld_out_cell;
   localparam int NT = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NT-1:0] term = '0;
   logic oe = 1'b0, pin = 1'b0, adj = 1'b0;
   logic g0 = 1'b0, g1 = 1'b1, ls = 1'b0, pol = 1'b0;
   logic pld = 1'b0, pdat = 1'b0;
   logic o_in, en_in, fb_in;
   logic o_ed, en_ed, fb_ed;
   logic o_md, en_md, fb_md;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pld_out_cell #(.N_TERMS(NT), .CELL_KIND(0)) i_pld_out_cell (
      .clk(clk), .rst(rst), .term_i(term), .oe_i(oe), .pin_i(pin), .adj_i(adj),
      .g_sel0(g0), .g_sel1(g1), .l_sel(ls), .l_pol(pol),
      .pre_ld_i(pld), .pre_dat_i(pdat),
      .pin_o(o_in), .pin_en_o(en_in), .fb_o(fb_in));

   pld_out_cell #(.N_TERMS(NT), .CELL_KIND(1)) i_pld_out_cell_edge (
      .clk(clk), .rst(rst), .term_i(term), .oe_i(oe), .pin_i(pin), .adj_i(adj),
      .g_sel0(g0), .g_sel1(g1), .l_sel(ls), .l_pol(pol),
      .pre_ld_i(pld), .pre_dat_i(pdat),
      .pin_o(o_ed), .pin_en_o(en_ed), .fb_o(fb_ed));

   pld_out_cell #(.N_TERMS(NT), .CELL_KIND(2)) i_pld_out_cell_mid (
      .clk(clk), .rst(rst), .term_i(term), .oe_i(oe), .pin_i(pin), .adj_i(adj),
      .g_sel0(g0), .g_sel1(g1), .l_sel(ls), .l_pol(pol),
      .pre_ld_i(pld), .pre_dat_i(pdat),
      .pin_o(o_md), .pin_en_o(en_md), .fb_o(fb_md));

   // {g0,g1,l}[17:15] pol[14] oe[13] term[12:5] pin[4] adj[3] | exp pin_o[2] en[1] fb[0]
   localparam int NV = 11;
   localparam logic [17:0] VEC [NV] = '{
      18'b100_1_0_00000000_0_1_011,  // R5 dedicated out, sum 0, active high
      18'b100_0_0_00000000_0_0_110,  // R2 R5 active low inverts
      18'b100_1_0_10000000_0_0_110,  // R5 top term counts
      18'b111_1_0_10000000_1_0_011,  // R4 top term is enable only
      18'b111_1_0_00000100_0_1_100,  // R4 low term sums, enable off
      18'b011_0_0_10000001_1_0_011,  // R4 registered-device I/O, inverted
      18'b101_1_0_11111111_1_1_001,  // R6 input takes adjacent pin
      18'b101_0_0_00000000_0_0_000,  // R6 driver off, pin_o low
      18'b000_1_1_11111111_1_1_000,  // R7 undefined
      18'b110_0_1_11111111_1_1_000,  // R7 undefined
      18'b001_1_1_11111111_1_1_000   // R7 undefined
   };

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic a, input logic b, input logic c, input logic p);
      g0 = a; g1 = b; ls = c; pol = p;
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R9 reset while held, both polarities
      cfg(0, 1, 0, 0); oe = 1'b1;
      #1;
      chk("R9 reset pin_o pol0", o_in, 1'b1);
      chk("R3 reg enable follows oe", en_in, 1'b1);
      pol = 1'b1; #1;
      chk("R9 reset pin_o pol1", o_in, 1'b1);
      @(negedge clk); rst = 1'b0;

      // R1 R2 R4..R7 table on the inner cell
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {g0, g1, ls} = VEC[i][17:15];
         pol  = VEC[i][14];
         oe   = VEC[i][13];
         term = VEC[i][12:5];
         pin  = VEC[i][4];
         adj  = VEC[i][3];
         #1;
         chk($sformatf("R1 vec%0d pin_o", i), o_in, VEC[i][2]);
         chk($sformatf("R1 vec%0d pin_en_o", i), en_in, VEC[i][1]);
         chk($sformatf("R1 vec%0d fb_o", i), fb_in, VEC[i][0]);
      end

      // R3 registered path
      @(negedge clk); cfg(0, 1, 0, 1); oe = 1'b1; term = 8'b0000_0001;
      @(posedge clk); #1;
      chk("R3 reg loads one", o_in, 1'b1);
      chk("R3 fb equals pin", fb_in, 1'b1);
      @(negedge clk); term = 8'h00;
      #1;
      chk("R3 pin_o holds until edge", o_in, 1'b1);
      @(posedge clk); #1;
      chk("R3 reg loads zero", o_in, 1'b0);
      chk("R3 fb follows register", fb_in, 1'b0);
      @(negedge clk); pol = 1'b0; oe = 1'b0;
      @(posedge clk); #1;
      chk("R3 active low loads inverse", o_in, 1'b1);
      chk("R3 enable off with oe", en_in, 1'b0);

      // R10 preload overrides next state for one edge
      @(negedge clk); pol = 1'b1; term = 8'h00; pld = 1'b1; pdat = 1'b1;
      @(posedge clk); #1;
      chk("R10 preload value", o_in, 1'b1);
      @(negedge clk); pld = 1'b0;
      @(posedge clk); #1;
      chk("R10 next state after preload", o_in, 1'b0);
      @(negedge clk); pld = 1'b1; pdat = 1'b1; rst = 1'b1; pol = 1'b0; term = 8'hFF;
      @(posedge clk); #1;
      chk("R10 reset beats preload", o_in, 1'b1);
      @(negedge clk); pld = 1'b0; pdat = 1'b0; rst = 1'b0;
      @(posedge clk); #1;
      chk("R9 after reset loads inverse", o_in, 1'b0);

      // R8 end cell feedback steering
      @(negedge clk); cfg(1, 1, 1, 1); term = 8'h00; pin = 1'b1; adj = 1'b0;
      #1;
      chk("R8 edge non-reg io fb=adj", fb_ed, 1'b0);
      chk("R4 inner non-reg io fb=pin", fb_in, 1'b1);
      @(negedge clk); cfg(0, 1, 1, 1);
      #1;
      chk("R8 edge reg-device io fb=pin", fb_ed, 1'b1);
      @(negedge clk); cfg(0, 1, 0, 1); term = 8'h01;
      @(posedge clk); #1;
      chk("R8 edge registered fb=reg", fb_ed, 1'b1);

      // R5 centre cell
      @(negedge clk); cfg(1, 0, 0, 1); adj = 1'b1;
      #1;
      chk("R5 centre dout fb zero", fb_md, 1'b0);
      chk("R5 inner dout fb adj", fb_in, 1'b1);
      chk("R5 centre dout enabled", en_md, 1'b1);
      @(negedge clk); cfg(1, 0, 1, 1);
      #1;
      chk("R6 centre input fb adj", fb_md, 1'b1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule